// File: doc/BRIEF.md
# Bit-Reset Prescaled PWM Generator

This block drives a single pulse-width modulated output from an 8-bit counter. The counter advances on a slow tick enable, nominally 32 kHz. It does not stop at a programmed terminal count. Instead, a 2-bit prescaler picks one counter bit, and the counter returns to zero at the moment an increment would set that bit. Prescaler 0 picks bit 7, prescaler 1 picks bit 6, prescaler 2 picks bit 5 and prescaler 3 picks bit 4. The period is therefore 128, 64, 32 or 16 ticks.

Two byte-wide registers hold the configuration and are reached through a simple port with a write strobe, a read strobe and a 1-bit address. The control register holds the enable and the prescaler. The duty register holds a 7-bit high-time count. The output is high while the counter bits below the selected reset bit are strictly less than the duty value. A duty write takes effect on the very next cycle. A prescaler change keeps the counter's current value, and counting continues under the new reset bit.

Top module: `pwm_bitreset`

## Requirements
- R1: After reset, both registers read as 0x00 and the output is low, so the block comes up disabled with prescaler 0 and duty 0.
- R2: Address 0 is the control register: bit 7 is the enable and bits 1:0 are the prescaler. Bits 6:2 are ignored on write and read back as 0. Read data appears one clock after the read strobe.
- R3: Address 1 is the duty register. Bits 6:0 are stored. Bit 7 is ignored on write and reads back as 0.
- R4: While the enable is 0, the output is low and the counter is held at zero. After enabling, the first period starts at counter value 0.
- R5: The counter moves only on a clock that has the tick input high. With prescaler p, the output pattern repeats every 128>>p ticks.
- R6: With the enable set, the output is high while the counter bits below the reset bit are less than the duty value, and low otherwise. Within each period, the output is high for min(duty, period) ticks, starting at counter value 0.
- R7: A duty at or above the period length gives a constant-high output. With prescaler 0, the largest duty (127) still leaves one low tick per 128.
- R8: Changing the prescaler does not clear the counter. Counting continues from the present value until an increment sets the newly selected reset bit.
- R9: A new duty value changes the output on the cycle after the write, without waiting for the end of the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Counter advance enable (time base tick) |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 1 | Register select: 0 control, 1 duty |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| pwm_o | output | 1 | PWM output |

## Verification
The output is decoded combinationally from the registered counter and the configuration registers. It therefore settles right after the rising edge that takes a write or a tick. The bench drives every stimulus and samples every result on falling edges, so each sample falls half a clock after the edge that changed the state.

Read data is registered and is checked on the falling edge one clock after the strobe. When the enable is cleared, the counter is zeroed on the edge after the control write, and the bench always spends at least one more write cycle before it enables again.

Across all four prescalers and six duty values, the sweep counts ticks and compares each sample with (count mod period) < duty.

// File: rtl/pwm_br_pkg.sv
package pwm_br_pkg;
  localparam int CNT_W_DEF = 8;
  localparam int PSC_W_DEF = 2;
  localparam int DAT_W_DEF = 8;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_DUTY = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/pwm_br_regs.sv
module pwm_br_regs
  import pwm_br_pkg::*;
#(
  parameter int DAT_W = DAT_W_DEF,
  parameter int PSC_W = PSC_W_DEF,
  localparam int DUTY_W = DAT_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              addr_i,
  input  logic [DAT_W-1:0]  wdata_i,
  output logic [DAT_W-1:0]  rdata_o,
  output logic              run_o,
  output logic [PSC_W-1:0]  psc_o,
  output logic [DUTY_W-1:0] duty_o
);
  logic              en_q, en_d;
  logic [PSC_W-1:0]  psc_q, psc_d;
  logic [DUTY_W-1:0] duty_q, duty_d;
  logic [DAT_W-1:0]  rdata_q, rdata_d, rd_mux;
  logic              wr_ctrl, wr_duty;

  assign wr_ctrl = wr_i && (addr_i == SEL_CTRL);
  assign wr_duty = wr_i && (addr_i == SEL_DUTY);

  always_comb begin
    en_d   = en_q;
    psc_d  = psc_q;
    duty_d = duty_q;
    if (wr_ctrl) begin
      en_d  = wdata_i[DAT_W-1];
      psc_d = wdata_i[PSC_W-1:0];
    end
    if (wr_duty) duty_d = wdata_i[DUTY_W-1:0];
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == SEL_CTRL) begin
      rd_mux[DAT_W-1]   = en_q;
      rd_mux[PSC_W-1:0] = psc_q;
    end else begin
      rd_mux[DUTY_W-1:0] = duty_q;
    end
    rdata_d = rd_i ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      psc_q   <= '0;
      duty_q  <= '0;
      rdata_q <= '0;
    end else begin
      en_q    <= en_d;
      psc_q   <= psc_d;
      duty_q  <= duty_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;
  assign run_o   = en_q;
  assign psc_o   = psc_q;
  assign duty_o  = duty_q;

  // R2
  ctrl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> (en_q == $past(wdata_i[DAT_W-1])) && (psc_q == $past(wdata_i[PSC_W-1:0])));

  // R3
  duty_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_duty |=> duty_q == $past(wdata_i[DUTY_W-1:0]));
endmodule

// File: rtl/pwm_br_counter.sv
module pwm_br_counter
  import pwm_br_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF,
  parameter int PSC_W = PSC_W_DEF,
  localparam int IDX_W = $clog2(CNT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [IDX_W-1:0] rbit;

  always_comb begin
    cnt_inc = cnt_q + 1'b1;
    rbit    = IDX_W'(CNT_W - 1) - IDX_W'(psc_i);
    cnt_d   = cnt_q;
    if (!run_i)      cnt_d = '0;
    else if (tick_i) cnt_d = cnt_inc[rbit] ? '0 : cnt_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R4
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);

  // R5
  cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_br_compare.sv
module pwm_br_compare
  import pwm_br_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF,
  parameter int PSC_W = PSC_W_DEF,
  localparam int DUTY_W = CNT_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [PSC_W-1:0]  psc_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              pwm_o
);
  logic [CNT_W-1:0] low_mask, cnt_low;
  logic [CNT_W:0]   per_len;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      low_mask[i] = (i < (CNT_W - 1 - int'(psc_i)));
    end
    cnt_low = cnt_i & low_mask;
    per_len = {1'b0, low_mask} + 1'b1;
  end

  assign pwm_o = run_i && (cnt_low < {1'b0, duty_i});

  // R7
  sat_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && ({2'b00, duty_i} >= per_len)) |-> pwm_o);
endmodule

// File: rtl/pwm_bitreset.sv
module pwm_bitreset
  import pwm_br_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF,
  parameter int PSC_W = PSC_W_DEF,
  localparam int DAT_W = CNT_W,
  localparam int DUTY_W = CNT_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             addr_i,
  input  logic [DAT_W-1:0] wdata_i,
  output logic [DAT_W-1:0] rdata_o,
  output logic             pwm_o
);
  logic              rst_meta_q, rst_sync_q;
  logic              run;
  logic [PSC_W-1:0]  psc;
  logic [DUTY_W-1:0] duty;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pwm_br_regs #(.DAT_W(DAT_W), .PSC_W(PSC_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_q),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .run_o   (run),
    .psc_o   (psc),
    .duty_o  (duty)
  );

  pwm_br_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_q),
    .run_i  (run),
    .tick_i (tick_i),
    .psc_i  (psc),
    .cnt_o  (cnt)
  );

  pwm_br_compare #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_q),
    .run_i  (run),
    .psc_i  (psc),
    .duty_i (duty),
    .cnt_i  (cnt),
    .pwm_o  (pwm_o)
  );
endmodule

// File: tb/sim_pwm_bitreset.sv
module sim_pwm_bitreset;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr = 1'b0, rd = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pwm;
  int         checks = 0, errors = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  pwm_bitreset u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] d);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic tick1();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic sweep(input int psc, input int cyc);
    int per, eff;
    per = 128 >> psc;
    eff = cyc & 127;
    wr_reg(1'b0, 8'h00);
    wr_reg(1'b1, 8'(cyc));
    wr_reg(1'b0, 8'(8'h80 | psc));
    for (int k = 0; k <= per; k++) begin
      chk($sformatf("R6 psc=%0d duty=%0d k=%0d", psc, cyc, k), pwm, ((k % per) < eff) ? 1 : 0);
      if (k == 3) begin
        repeat (3) @(negedge clk);
        chk("R5 idle hold", pwm, (3 < eff) ? 1 : 0);
      end
      tick1();
    end
  endtask

  initial begin
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R1 pwm low", pwm, 0);
    rd_reg(1'b0, d); chk("R1 ctrl", d, 0);
    rd_reg(1'b1, d); chk("R1 duty", d, 0);

    wr_reg(1'b0, 8'h7E);
    rd_reg(1'b0, d); chk("R2 ctrl readback", d, 8'h02);
    wr_reg(1'b0, 8'h00);
    wr_reg(1'b1, 8'hFF);
    rd_reg(1'b1, d); chk("R3 duty bit7 dropped", d, 8'h7F);
    rd_reg(1'b0, d); chk("R2 ctrl after duty write", d, 8'h00);

    // R4: disabled output stays low across ticks, counter restarts at 0
    wr_reg(1'b1, 8'd1);
    for (int i = 0; i < 5; i++) begin tick1(); chk("R4 disabled low", pwm, 0); end
    wr_reg(1'b0, 8'h83);
    chk("R4 starts at zero", pwm, 1);
    tick1();
    chk("R4 after one tick", pwm, 0);

    for (int p = 0; p < 4; p++) begin
      int per;
      per = 128 >> p;
      sweep(p, 0);
      sweep(p, 1);
      sweep(p, per / 2);
      sweep(p, per - 1);
      sweep(p, per);     // R7 constant high for p>0
      sweep(p, 127);     // R7 p=0 leaves one low tick
    end

    // R8: prescaler change keeps the counter
    wr_reg(1'b0, 8'h00);
    wr_reg(1'b1, 8'd10);
    wr_reg(1'b0, 8'h80);
    for (int i = 0; i < 40; i++) tick1();
    wr_reg(1'b0, 8'h83);
    chk("R8 low bits 8 < 10", pwm, 1);
    tick1(); tick1();
    chk("R8 low bits 10 not below 10", pwm, 0);
    for (int i = 0; i < 5; i++) tick1();
    chk("R8 low bits 15", pwm, 0);
    tick1();
    chk("R8 wrapped to zero", pwm, 1);

    // R9: duty write acts at once
    wr_reg(1'b1, 8'd5);
    for (int i = 0; i < 8; i++) tick1();
    chk("R9 before duty write", pwm, 0);
    wr_reg(1'b1, 8'd12);
    chk("R9 after duty write", pwm, 1);
    wr_reg(1'b1, 8'd3);
    chk("R9 after lowering duty", pwm, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule